// File: doc/BRIEF.md
# Programmable Binary Timer with One-Shot

The block counts strobes of a count-enable input through a chain of toggle stages. Its single output follows one of four taps on that chain. A two-bit select picks the tap. The chain can also be split so that its upper part counts the strobe directly, which gives a short period from the top tap.

In recycle mode the output is a free-running square wave. In single-cycle mode the output flips once, half a selected period after the last clear, and then stays where it is until the block is re-armed. A polarity input sets the level the output takes while the block is held in reset. With polarity high and single-cycle mode, the block acts as a retriggerable one-shot: a master reset pulse drives the output high, and the output falls once the selected count has elapsed.

Clearing has three sources: a synchronous master reset, any change of the mode level, and an optional stretched clear that follows power-on. The stretched clear is enabled by holding the auto-reset input low.

Top module: `prog_timer`

## Requirements
- R1: The select {sel_a, sel_b} chooses the tap: 2'b00 selects stage 13, 2'b01 selects stage 10, and 2'b11 selects stage 16. Stage n is the n-th toggle stage, with stage 1 the fastest. In recycle mode, q first changes after exactly 2^(n-1) counted ticks since the last clear.
- R2: With {sel_a, sel_b} = 2'b10, stages 9 to 16 count every tick directly instead of the carry from stage 8, and stage 16 is the output. The output therefore first changes after 128 counted ticks, and the period is 256.
- R3: While mr is high, q equals pol in the same cycle. On the next edge the counter and the single-cycle latch are cleared, even if tick is high.
- R4: A clock edge with tick low and no clear leaves the count unchanged.
- R5: With mode=1, q = pol XOR tap. The output toggles every 2^(n-1) ticks, so the period is 2^n ticks.
- R6: With mode=0, q equals pol until 2^(n-1) ticks have been counted after a clear, then equals NOT pol. It holds that level whatever further ticks arrive.
- R7: A change in the level of mode clears the counter and the latch on the next edge, which re-arms a single-cycle run.
- R8: por_n low resets all state asynchronously. After por_n rises, if ar_n is low, the first 4 clock edges act as clears and the ticks on them are not counted. If ar_n is high, counting starts on the first edge.
- R9: In reset (por_n low, or mr high), q equals pol. With pol=1 and mode=0, q is high after a master reset and falls once the selected count elapses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| tick | input | 1 | Count-enable strobe |
| mr | input | 1 | Synchronous master reset, active high |
| ar_n | input | 1 | Low enables the stretched clear after power-on |
| sel_a | input | 1 | Tap select, upper bit |
| sel_b | input | 1 | Tap select, lower bit |
| pol | input | 1 | Output level while in reset |
| mode | input | 1 | 1 = recycle, 0 = single cycle |
| q | output | 1 | Timer output |

## Verification
The assertions take all inputs as synchronous to clk. They also take the tap select as steady while a run is in progress, because a select change mid-run makes the tap jump and none of the properties model that. The bench drives every input at the falling edge. It changes the select only together with a master reset, and it toggles mode only at the points where it means to re-arm. Its expected output levels are derived from powers of two of the chosen stage.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;

   // Encoding of {sel_a, sel_b}
   typedef enum logic [1:0] {
      TSEL_MID    = 2'b00,
      TSEL_LOW    = 2'b01,
      TSEL_SPLIT  = 2'b10,
      TSEL_TOP    = 2'b11
   } tap_sel_e;

   function automatic logic is_split(input tap_sel_e s);
      return (s == TSEL_SPLIT);
   endfunction

endpackage

// File: rtl/prog_timer_chain.sv
module prog_timer_chain #(
   parameter int STAGES      = 16,
   parameter int SPLIT_STAGE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic              split,
   output logic [STAGES-1:0] cnt_o
);
   localparam int UP_W = STAGES - SPLIT_STAGE;

   initial begin
      assert (SPLIT_STAGE >= 1 && SPLIT_STAGE < STAGES)
         else $error("chain split stage out of range");
   end

   logic [STAGES-1:0] en;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic bit_q;
      if (i == 0) begin : g_first
         assign en[i] = tick;
      end else if (i == SPLIT_STAGE) begin : g_split
         assign en[i] = split ? tick : (en[i-1] & cnt_o[i-1]);
      end else begin : g_ripple
         assign en[i] = en[i-1] & cnt_o[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bit_q <= 1'b0;
         else if (clr)    bit_q <= 1'b0;
         else if (en[i])  bit_q <= ~bit_q;
      end
      assign cnt_o[i] = bit_q;
   end

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(cnt_o));                             // R4

   AST_SPLIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (split && tick && !clr) |=>
         (cnt_o[STAGES-1:SPLIT_STAGE] ==
          UP_W'($past(cnt_o[STAGES-1:SPLIT_STAGE]) + 1'b1)));          // R2

endmodule

// File: rtl/prog_timer_por.sv
module prog_timer_por #(
   parameter int POR_CYCLES = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic ar_n,
   output logic por_clr
);
   initial begin
      assert (POR_CYCLES >= 0) else $error("negative power-on stretch");
   end

   if (POR_CYCLES == 0) begin : g_none
      assign por_clr = 1'b0;
   end else begin : g_stretch
      localparam int CW = $clog2(POR_CYCLES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)               cnt_q <= '0;
         else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
      end
      assign por_clr = !ar_n && (cnt_q != LIMIT);

      AST_POR_BOUNDED: assert property (@(posedge clk) disable iff (!por_n)
         cnt_q <= LIMIT);                                              // R8
   end

endmodule

// File: rtl/prog_timer_out.sv
module prog_timer_out (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic force_lvl,
   input  logic tap,
   input  logic mode,
   input  logic pol,
   output logic latch_o,
   output logic q
);
   logic latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      latch_q <= 1'b0;
      else if (clr)    latch_q <= 1'b0;
      else if (tap)    latch_q <= 1'b1;
   end

   always_comb begin
      if (force_lvl)   q = pol;
      else if (mode)   q = tap ^ pol;
      else             q = (latch_q | tap) ^ pol;
   end

   assign latch_o = latch_q;

endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
   parameter int STAGES      = 16,
   parameter int SPLIT_STAGE = 8,
   parameter int TAP_MID     = 13,
   parameter int TAP_LOW     = 10,
   parameter int POR_CYCLES  = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic tick,
   input  logic mr,
   input  logic ar_n,
   input  logic sel_a,
   input  logic sel_b,
   input  logic pol,
   input  logic mode,
   output logic q
);
   import prog_timer_pkg::*;

   initial begin
      assert (TAP_MID >= 1 && TAP_MID <= STAGES) else $error("mid tap out of range");
      assert (TAP_LOW >= 1 && TAP_LOW <= STAGES) else $error("low tap out of range");
      assert (SPLIT_STAGE < STAGES) else $error("split must sit below top tap");
   end

   tap_sel_e          sel;
   logic [STAGES-1:0] cnt;
   logic              tap, split, por_clr, mode_q, mode_seen, mode_chg;
   logic              clr, force_lvl, latch;

   assign sel   = tap_sel_e'({sel_a, sel_b});
   assign split = is_split(sel);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mode_q    <= 1'b0;
         mode_seen <= 1'b0;
      end else begin
         mode_q    <= mode;
         mode_seen <= 1'b1;
      end
   end

   assign mode_chg  = mode_seen && (mode != mode_q);
   assign force_lvl = mr | por_clr;
   assign clr       = force_lvl | mode_chg;

   always_comb begin
      unique case (sel)
         TSEL_MID: tap = cnt[TAP_MID-1];
         TSEL_LOW: tap = cnt[TAP_LOW-1];
         default:  tap = cnt[STAGES-1];
      endcase
   end

   prog_timer_por #(.POR_CYCLES(POR_CYCLES)) por_i (
      .clk(clk), .por_n(por_n), .ar_n(ar_n), .por_clr(por_clr));

   prog_timer_chain #(.STAGES(STAGES), .SPLIT_STAGE(SPLIT_STAGE)) chain_i (
      .clk(clk), .rst_n(por_n), .clr(clr), .tick(tick), .split(split),
      .cnt_o(cnt));

   prog_timer_out out_i (
      .clk(clk), .rst_n(por_n), .clr(clr), .force_lvl(force_lvl),
      .tap(tap), .mode(mode), .pol(pol), .latch_o(latch), .q(q));

   AST_MR_LEVEL: assert property (@(posedge clk) disable iff (!por_n)
      mr |-> (q == pol));                                              // R3

   AST_MR_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
      mr |=> (cnt == '0 && !latch));                                   // R3

   AST_POR_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
      por_clr |=> (cnt == '0));                                        // R8

   AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (latch && !mode && !clr) |=> (mr || por_clr || mode || q != pol)); // R6

   AST_MODE_REARM: assert property (@(posedge clk) disable iff (!por_n)
      mode_chg |=> (!latch && cnt == '0));                             // R7

endmodule

// File: tb/prog_timer_tb_top.sv
module prog_timer_tb_top;
   logic clk = 1'b0;
   logic por_n, tick, mr, ar_n, sel_a, sel_b, pol, mode;
   logic q;
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   prog_timer dut_i (
      .clk(clk), .por_n(por_n), .tick(tick), .mr(mr), .ar_n(ar_n),
      .sel_a(sel_a), .sel_b(sel_b), .pol(pol), .mode(mode), .q(q));

   task automatic check(input logic exp, input string tag);
      n_checks++;
      if (q !== exp) begin
         n_fail++;
         $display("FAIL %s: q actual=%b expected=%b", tag, q, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run(input int k);
      tick = 1'b1;
      cyc(k);
      tick = 1'b0;
   endtask

   task automatic clear(input logic a, input logic b);
      sel_a = a; sel_b = b;
      mr = 1'b1;
      #1;
      check(pol, "R3 level during mr");
      cyc(1);
      mr = 1'b0;
   endtask

   initial begin
      int fin = 0;
      while (!done && fin < 190000) begin
         @(posedge clk);
         fin++;
      end
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      por_n = 1'b0; tick = 1'b0; mr = 1'b0; ar_n = 1'b0;
      sel_a = 1'b1; sel_b = 1'b0; pol = 1'b0; mode = 1'b1;
      cyc(2);
      check(1'b0, "R9 por level pol=0");
      pol = 1'b1; #1;
      check(1'b1, "R9 por level pol=1");
      pol = 1'b0;

      // R8: stretched clear with ar_n low eats the first 4 ticks
      por_n = 1'b1;
      run(131);
      check(1'b0, "R8 ar_n=0 127 counted");
      run(1);
      check(1'b1, "R8 ar_n=0 128 counted");

      // R8: no stretch with ar_n high
      por_n = 1'b0; ar_n = 1'b1; cyc(2);
      por_n = 1'b1;
      run(127);
      check(1'b0, "R8 ar_n=1 127 counted");
      run(1);
      check(1'b1, "R8 ar_n=1 128 counted");

      // R1/R5/R2: recycle sweep over taps, both polarities
      for (int p = 0; p < 2; p++) begin
         pol = p[0];
         for (int s = 0; s < 4; s++) begin
            int n;
            int half;
            n = (s == 0) ? 13 : (s == 1) ? 10 : (s == 2) ? 8 : 16;
            half = 1 << (n - 1);
            if (p == 1 && s == 3) continue;
            clear(s[1], s[0]);
            run(half - 1);
            check(pol, "R1 R2 before first toggle");
            run(1);
            check(~pol, "R1 R2 first toggle");
            if (s != 3) begin
               run(half - 1);
               check(~pol, "R5 before second toggle");
               run(1);
               check(pol, "R5 full period");
            end
         end
      end

      // R6/R9: single cycle, pol=1, stage 10
      pol = 1'b1;
      mode = 1'b0; cyc(2);
      clear(1'b0, 1'b1);
      check(1'b1, "R9 high after reset");
      run(511);
      check(1'b1, "R6 before flip");
      run(1);
      check(1'b0, "R6 R9 flipped low");
      run(512);
      check(1'b0, "R6 holds after more ticks");
      run(1024);
      check(1'b0, "R6 holds over full period");

      // R4: tick low does not count
      clear(1'b0, 1'b1);
      run(511);
      cyc(50);
      check(1'b1, "R4 no count when idle");
      run(1);
      check(1'b0, "R4 resumes count");

      // R3: mr wins over tick
      clear(1'b0, 1'b1);
      run(300);
      tick = 1'b1; mr = 1'b1; #1;
      check(1'b1, "R3 level with tick high");
      cyc(1);
      mr = 1'b0;
      run(511);
      check(1'b1, "R3 count restarted");
      run(1);
      check(1'b0, "R3 flip after restart");

      // R7: mode change re-arms
      mode = 1'b1; cyc(1);
      check(1'b1, "R7 cleared on mode change");
      mode = 1'b0; cyc(1);
      run(511);
      check(1'b1, "R7 rearmed before flip");
      run(1);
      check(1'b0, "R7 rearmed flip");

      // R2: single cycle on the split tap
      pol = 1'b0;
      clear(1'b1, 1'b0);
      run(127);
      check(1'b0, "R2 single before flip");
      run(1);
      check(1'b1, "R2 single flip");
      run(300);
      check(1'b1, "R2 single holds");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule